// File: doc/BRIEF.md
# Receive DMA Descriptor Poll Controller

This block is the control side of a descriptor-driven DMA engine. A CPU reaches it through a plain 32-bit register port. The port gives access to the base address of the transmit descriptor list and the base address of the receive descriptor list. It also has a write-only "poll" location and a sticky error register. The block tracks the receive process as stopped, running or suspended, and the transmit process as stopped or running. Dedicated enable and stop inputs move each process between its states.

A write of any data value to the poll location asks the receive side to look for a free descriptor. Availability arrives as a single input flag, sampled on that write. If the flag shows a descriptor, the receive process goes to (or stays in) running. If it does not, the process parks in suspended until the next poll. Each time the receive process enters running, the block raises a one-cycle fetch request toward the memory engine. Descriptor memory traffic and frame data movement happen outside this block.

Base addresses may only change while their own process is stopped. A write at any other time is dropped and recorded as an error. The two low bits of an accepted base are cleared to keep it word aligned, and a separate flag notes that they were nonzero.

Top module: `rxdma_poll_ctrl`

## Requirements
- R1: After reset both base registers and the error register read 0, `rx_state` is 0 (stopped), `tx_running` is 0 and `rx_fetch_req` is 0.
- R2: A write of any value to offset 0x0C while `rx_state` is 1 (running) or 2 (suspended) sets `rx_state` to 1 when `rx_desc_avail` is 1, and to 2 when it is 0. The new state is visible in the cycle after the write.
- R3: A write to offset 0x0C while `rx_state` is 0 leaves it 0. Reads of offset 0x0C, and of any unmapped offset, return 0.
- R4: `rx_enable` moves the receive process from stopped to running and has no effect in any other state. `rx_stop` returns it to stopped from any state and wins over `rx_enable` in the same cycle.
- R5: `tx_enable` sets `tx_running` from stopped, and `tx_stop` clears it, with stop winning over enable in the same cycle.
- R6: `rx_fetch_req` is high for exactly one cycle each time `rx_state` enters 1 from 0 or 2. It stays low while the state remains 1.
- R7: The transmit base at offset 0x10 and the receive base at offset 0x14 take a written value only while their own process is stopped. The value is stored with bits [1:0] cleared and reads back as stored.
- R8: A base write made while its process is not stopped leaves the register unchanged. It sets bit 0 (transmit) or bit 1 (receive) of the error register at offset 0x18.
- R9: An accepted base write whose bits [1:0] are nonzero sets bit 2 (transmit) or bit 3 (receive) of the error register.
- R10: Error bits stay set until a write to offset 0x18 with a 1 in that bit position. A 0 in a bit position leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_enable | input | 1 | Start the receive process |
| rx_stop | input | 1 | Stop the receive process |
| tx_enable | input | 1 | Start the transmit process |
| tx_stop | input | 1 | Stop the transmit process |
| rx_desc_avail | input | 1 | A receive descriptor is owned by the engine |
| rx_fetch_req | output | 1 | One-cycle request to fetch a descriptor |
| rx_state | output | 2 | Receive process: 0 stopped, 1 running, 2 suspended |
| tx_running | output | 1 | Transmit process running |

## Verification
A wrong receive state shows at the ports one cycle after the event that caused it, on `rx_state` and `rx_fetch_req`. The next base write also exposes it, because the write is accepted or refused according to the state, and the result reads straight back. The bench drives the receive process into each of its three states. In each state it applies every combination of poll and descriptor flag, then base writes with all four low-bit patterns, and compares the state, the fetch pulse, the readback and the error bits against values it derives itself.

// File: rtl/rxdma_pkg.sv
// Shared types and register offsets for the receive DMA poll controller.
// Assumes byte offsets that fit in 8 bits.
package rxdma_pkg;

    typedef enum logic [1:0] {
        PS_STOPPED   = 2'd0,
        PS_RUNNING   = 2'd1,
        PS_SUSPENDED = 2'd2
    } proc_state_t;

    localparam int OFS_POLL   = 8'h0C;
    localparam int OFS_TXBASE = 8'h10;
    localparam int OFS_RXBASE = 8'h14;
    localparam int OFS_ERR    = 8'h18;

    localparam int NUM_CH = 2;   // channel 0 transmit, channel 1 receive
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

endpackage

// File: rtl/rxdma_rx_fsm.sv
// Receive process state machine. Enable starts it from stopped and stop
// halts it from any state. A poll demand samples descriptor availability
// and picks running or suspended. Produces a one-cycle fetch pulse on every
// entry into running. Assumes poll is a single-cycle strobe.
module rxdma_rx_fsm
    import rxdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        stop,
    input  logic        poll,
    input  logic        desc_avail,
    output proc_state_t state,
    output logic        fetch_req
);

    proc_state_t state_q, state_d;
    logic        fetch_q;

    // Next-state choice: stop first, then start from stopped, then poll.
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = PS_STOPPED;
        end else if (state_q == PS_STOPPED) begin
            if (enable) state_d = PS_RUNNING;
        end else if (poll) begin
            state_d = desc_avail ? PS_RUNNING : PS_SUSPENDED;
        end
    end

    // State and fetch-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_STOPPED;
            fetch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fetch_q <= (state_d == PS_RUNNING) && (state_q != PS_RUNNING);
        end
    end

    assign state     = state_q;
    assign fetch_req = fetch_q;

endmodule

// File: rtl/rxdma_tx_fsm.sv
// Transmit process run flag. Enable sets it, stop clears it, and stop wins
// when both arrive together. Assumes both inputs are level or pulse strobes.
module rxdma_tx_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stop,
    output logic running
);

    logic run_q;

    // Run flag update with stop priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (stop)   run_q <= 1'b0;
        else if (enable) run_q <= 1'b1;
    end

    assign running = run_q;

endmodule

// File: rtl/rxdma_base_reg.sv
// One descriptor list base register. It accepts a write only while its own
// process is stopped and clears the low alignment bits on store. It reports
// a refused write and a misaligned accepted write as one-cycle pulses.
// Assumes ALIGN_BITS >= 1.
module rxdma_base_reg #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              proc_stopped,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base,
    output logic              busy_hit,
    output logic              misalign_hit
);

    logic [DATA_W-1:0] base_q;
    logic              accept;

    assign accept = wr_sel && proc_stopped;

    // Base storage, written only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (accept) base_q <= {wdata[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end

    assign base         = base_q;
    assign busy_hit     = wr_sel && !proc_stopped;
    assign misalign_hit = accept && (|wdata[ALIGN_BITS-1:0]);

endmodule

// File: rtl/rxdma_poll_ctrl.sv
// Top of the receive DMA poll controller. It decodes the register port,
// holds the two base registers and the sticky error flags, and drives the
// receive and transmit process machines. Reads are combinational. Assumes
// one register access per cycle and ADDR_W >= 8.
module rxdma_poll_ctrl
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_enable,
    input  logic              rx_stop,
    input  logic              tx_enable,
    input  logic              tx_stop,
    input  logic              rx_desc_avail,
    output logic              rx_fetch_req,
    output logic [1:0]        rx_state,
    output logic              tx_running
);

    localparam int ALIGN_BITS = $clog2(DATA_W / 8);
    localparam int ERR_W      = 2 * NUM_CH;

    logic              hit_poll, hit_err;
    logic [NUM_CH-1:0] hit_base;
    logic [NUM_CH-1:0] ch_stopped;
    logic [NUM_CH-1:0] busy_hit, misalign_hit;
    logic [DATA_W-1:0] base_q [NUM_CH];
    logic [ERR_W-1:0]  err_q, err_set, err_clr;
    proc_state_t       rx_st;
    logic              tx_run;

    // Register write decode.
    assign hit_poll             = reg_wr && (reg_addr == ADDR_W'(OFS_POLL));
    assign hit_err              = reg_wr && (reg_addr == ADDR_W'(OFS_ERR));
    assign hit_base[CH_TX]      = reg_wr && (reg_addr == ADDR_W'(OFS_TXBASE));
    assign hit_base[CH_RX]      = reg_wr && (reg_addr == ADDR_W'(OFS_RXBASE));
    assign ch_stopped[CH_TX]    = !tx_run;
    assign ch_stopped[CH_RX]    = (rx_st == PS_STOPPED);

    rxdma_rx_fsm u_rx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enable),
        .stop       (rx_stop),
        .poll       (hit_poll),
        .desc_avail (rx_desc_avail),
        .state      (rx_st),
        .fetch_req  (rx_fetch_req)
    );

    rxdma_tx_fsm u_tx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tx_enable),
        .stop    (tx_stop),
        .running (tx_run)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_base
        rxdma_base_reg #(
            .DATA_W     (DATA_W),
            .ALIGN_BITS (ALIGN_BITS)
        ) u_base (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_sel       (hit_base[c]),
            .proc_stopped (ch_stopped[c]),
            .wdata        (reg_wdata),
            .base         (base_q[c]),
            .busy_hit     (busy_hit[c]),
            .misalign_hit (misalign_hit[c])
        );
    end

    assign err_set = {misalign_hit, busy_hit};
    assign err_clr = hit_err ? reg_wdata[ERR_W-1:0] : '0;

    // Sticky error flags: write-one-to-clear, with a new set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    // Combinational read mux; the poll location and unmapped offsets read 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_TXBASE))      reg_rdata = base_q[CH_TX];
        else if (reg_addr == ADDR_W'(OFS_RXBASE)) reg_rdata = base_q[CH_RX];
        else if (reg_addr == ADDR_W'(OFS_ERR))    reg_rdata = DATA_W'(err_q);
    end

    assign rx_state   = rx_st;
    assign tx_running = tx_run;

endmodule

// File: rtl/rxdma_poll_ctrl_chk.sv
// Property checker for rxdma_poll_ctrl, bound into every instance.
module rxdma_poll_ctrl_chk
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rx_enable,
    input logic              rx_stop,
    input logic              tx_enable,
    input logic              tx_stop,
    input logic              rx_desc_avail,
    input logic              rx_fetch_req,
    input logic [1:0]        rx_state,
    input logic              tx_running,
    input logic [DATA_W-1:0] tx_base,
    input logic [DATA_W-1:0] rx_base
);

    logic poll;
    assign poll = reg_wr && (reg_addr == ADDR_W'(OFS_POLL));

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state != 2'd3);                                                          // R2
    AST_POLL_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && rx_state != 2'd0 && !rx_stop && rx_desc_avail) |=> rx_state == 2'd1); // R2
    AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && rx_state != 2'd0 && !rx_stop && !rx_desc_avail) |=> rx_state == 2'd2); // R2
    AST_POLL_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && rx_state == 2'd0 && !rx_enable) |=> rx_state == 2'd0);            // R3
    AST_RX_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop |=> rx_state == 2'd0);                                              // R4
    AST_TX_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> !tx_running);                                                   // R5
    AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !tx_stop) |=> tx_running);                                    // R5
    AST_FETCH_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fetch_req |-> (rx_state == 2'd1 && $past(rx_state) != 2'd1));            // R6
    AST_ENTRY_HAS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'd1 && $past(rx_state) != 2'd1) |-> rx_fetch_req);            // R6
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fetch_req |=> !rx_fetch_req);                                            // R6
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_base[1:0] == 2'b00) && (rx_base[1:0] == 2'b00));                        // R7
    AST_RX_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != 2'd0) |=> $stable(rx_base));                                   // R8
    AST_TX_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_running |=> $stable(tx_base));                                           // R8

endmodule

bind rxdma_poll_ctrl rxdma_poll_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .rx_enable     (rx_enable),
    .rx_stop       (rx_stop),
    .tx_enable     (tx_enable),
    .tx_stop       (tx_stop),
    .rx_desc_avail (rx_desc_avail),
    .rx_fetch_req  (rx_fetch_req),
    .rx_state      (rx_state),
    .tx_running    (tx_running),
    .tx_base       (base_q[0]),
    .rx_base       (base_q[1])
);

// File: tb/tb_rxdma_poll_ctrl.sv
module tb_rxdma_poll_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_enable = 1'b0, rx_stop = 1'b0, tx_enable = 1'b0, tx_stop = 1'b0;
    logic        rx_desc_avail = 1'b0;
    logic        rx_fetch_req;
    logic [1:0]  rx_state;
    logic        tx_running;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxdma_poll_ctrl dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .rx_enable (rx_enable), .rx_stop (rx_stop),
        .tx_enable (tx_enable), .tx_stop (tx_stop),
        .rx_desc_avail (rx_desc_avail), .rx_fetch_req (rx_fetch_req),
        .rx_state (rx_state), .tx_running (tx_running)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // sel: 0 rx_enable, 1 rx_stop, 2 tx_enable, 3 tx_stop, 4 rx_enable+rx_stop, 5 tx_enable+tx_stop
    task automatic pulse(input int sel);
        @(negedge clk);
        rx_enable = (sel == 0 || sel == 4);
        rx_stop   = (sel == 1 || sel == 4);
        tx_enable = (sel == 2 || sel == 5);
        tx_stop   = (sel == 3 || sel == 5);
        @(negedge clk);
        rx_enable = 1'b0; rx_stop = 1'b0; tx_enable = 1'b0; tx_stop = 1'b0;
    endtask

    // 0 stopped, 1 running, 2 suspended
    task automatic rx_goto(input int s);
        pulse(1);
        if (s >= 1) pulse(0);
        if (s == 2) begin
            rx_desc_avail = 1'b0;
            do_wr(8'h0C, 32'h0);
        end
    endtask

    task automatic tx_goto(input int s);
        if (s == 0) pulse(3);
        else begin pulse(3); pulse(2); end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, old, val, exp_base, exp_err;
        int exp_st;
        logic [31:0] poll_vals [3];
        poll_vals[0] = 32'h0; poll_vals[1] = 32'hFFFF_FFFF; poll_vals[2] = 32'h0000_005A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        do_rd(8'h10, rd); chk("R1", "tx base", rd, 32'h0);
        do_rd(8'h14, rd); chk("R1", "rx base", rd, 32'h0);
        do_rd(8'h18, rd); chk("R1", "errors", rd, 32'h0);
        chk("R1", "rx_state", 32'(rx_state), 32'd0);
        chk("R1", "tx_running", 32'(tx_running), 32'd0);
        chk("R1", "fetch", 32'(rx_fetch_req), 32'd0);

        // R3: unmapped and poll offsets read zero
        do_rd(8'h04, rd); chk("R3", "unmapped read", rd, 32'h0);

        // R4 / R6: enable from stopped gives running plus one fetch pulse
        pulse(0);
        chk("R4", "enable->running", 32'(rx_state), 32'd1);
        chk("R6", "fetch on start", 32'(rx_fetch_req), 32'd1);
        @(negedge clk);
        chk("R6", "fetch one cycle", 32'(rx_fetch_req), 32'd0);
        pulse(0);
        chk("R4", "enable while running", 32'(rx_state), 32'd1);
        chk("R6", "no fetch staying running", 32'(rx_fetch_req), 32'd0);
        pulse(4);
        chk("R4", "stop beats enable", 32'(rx_state), 32'd0);

        // R2 / R3 / R6: sweep start state x availability x poll data
        for (int s = 0; s < 3; s++) begin
            for (int av = 0; av < 2; av++) begin
                for (int v = 0; v < 3; v++) begin
                    rx_goto(s);
                    rx_desc_avail = av[0];
                    do_wr(8'h0C, poll_vals[v]);
                    exp_st = (s == 0) ? 0 : (av == 1 ? 1 : 2);
                    chk(s == 0 ? "R3" : "R2", "state after poll", 32'(rx_state), 32'(exp_st));
                    chk("R6", "fetch after poll", 32'(rx_fetch_req),
                        (exp_st == 1 && s != 1) ? 32'd1 : 32'd0);
                    do_rd(8'h0C, rd); chk("R3", "poll reads zero", rd, 32'h0);
                end
            end
            rx_goto(s);
            pulse(1);
            chk("R4", "stop from any state", 32'(rx_state), 32'd0);
        end

        // R5: transmit process
        tx_goto(0); pulse(2);
        chk("R5", "tx enable", 32'(tx_running), 32'd1);
        pulse(3);
        chk("R5", "tx stop", 32'(tx_running), 32'd0);
        pulse(2); pulse(5);
        chk("R5", "tx stop beats enable", 32'(tx_running), 32'd0);

        // R7..R10: base writes per channel, process state and low bits
        for (int ch = 0; ch < 2; ch++) begin
            for (int ps = 0; ps < (ch == 0 ? 2 : 3); ps++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    if (ch == 0) tx_goto(ps); else rx_goto(ps);
                    do_wr(8'h18, 32'hF);
                    do_rd(8'h18, rd); chk("R10", "cleared", rd, 32'h0);
                    do_rd(ch == 0 ? 8'h10 : 8'h14, old);
                    val = 32'hA5A5_0000 ^ (32'(ch) << 16) ^ (32'(ps) << 8) ^ (32'(lo) << 4) ^ 32'(lo);
                    do_wr(ch == 0 ? 8'h10 : 8'h14, val);
                    exp_base = (ps == 0) ? (val & 32'hFFFF_FFFC) : old;
                    exp_err  = (ps == 0) ? ((lo != 0) ? (32'h1 << (2 + ch)) : 32'h0)
                                         : (32'h1 << ch);
                    do_rd(ch == 0 ? 8'h10 : 8'h14, rd);
                    chk(ps == 0 ? "R7" : "R8", "base readback", rd, exp_base);
                    do_rd(8'h18, rd);
                    chk(ps == 0 ? "R9" : "R8", "error flags", rd, exp_err);
                    do_wr(8'h18, 32'h0);
                    do_rd(8'h18, rd); chk("R10", "sticky on zero write", rd, exp_err);
                    do_wr(8'h18, exp_err);
                    do_rd(8'h18, rd); chk("R10", "w1c", rd, 32'h0);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule